// File: doc/BRIEF.md
# Cycle and Retired-Instruction Counter Bank

This block keeps two 64-bit event counters for a processor core. One counts every clock cycle. The other counts each cycle in which the core reports a retired instruction. Both are reached through a 12-bit control-register address port. Each counter has two aliases. A user-visible alias only returns the count. A machine-level shadow alias reads the same register and can also load it. No second copy of the counter exists.

With a 32-bit data path (the default), each counter is split into two 32-bit halves. The upper half sits 0x80 above the address of the lower half. A load through the shadow alias replaces only the addressed half. In that cycle the load takes the place of the increment. Read data and the hit flag are registered. Each one returns the state the counter had before the clock edge that samples the address.

Privilege checks, event selection and enable gating are done outside this block. A load aimed at a read-only alias is therefore simply dropped here.

Top module: `tally_bank`

## Requirements
- R1: A synchronous active-high reset clears both counters, `rdata_o` and `hit_o` to zero.
- R2: Without a load to it, the cycle counter advances by one on every clock edge.
- R3: Without a load to it, the retired counter advances by one on each edge at which `retire_i` is 1, and holds otherwise.
- R4: The read-only aliases are 0xC00 for the cycle count and 0xC02 for the retired count, with their upper 32 bits at 0xC80 and 0xC82. `rdata_o` shows the value the addressed half had just before the edge that sampled `addr_i`, one cycle after the address is presented.
- R5: The shadow aliases 0xB00, 0xB02, 0xB80 and 0xB82 return the same register halves as 0xC00, 0xC02, 0xC80 and 0xC82.
- R6: With `we_i` set, a load at 0xB00 or 0xB02 puts `wdata_i` into bits 31:0 of that counter and keeps bits 63:32 unchanged. The counter does not increment in that cycle, even if `retire_i` is 1.
- R7: With `we_i` set, a load at 0xB80 or 0xB82 puts `wdata_i` into bits 63:32 and keeps bits 31:0 unchanged, again with no increment in that cycle.
- R8: A load at any 0xCxx alias changes neither counter. The hit flag and read data still behave as for a read.
- R9: `hit_o` is 1 only for the eight addresses listed in R4 and R5. For any other address, `hit_o` and `rdata_o` are 0 and a load has no effect.
- R10: When bits 31:0 roll over from 0xFFFFFFFF, bits 63:32 go up by one at the same edge. A full 64-bit count of all ones wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| addr_i | input | 12 | Control-register address |
| we_i | input | 1 | Write request for `addr_i` |
| wdata_i | input | XLEN (32) | Write data |
| rdata_o | output | XLEN (32) | Registered read data |
| hit_o | output | 1 | Registered flag: address decoded by this bank |

## Verification
The risky overlap is a shadow load landing in the same cycle as the counter's own increment. The bench provokes it in three ways: a load to the retired counter while `retire_i` is high, loads to the cycle counter (which always wants to count), and a load just before a carry into the upper half. A behavioural 64-bit model gives priority to the loaded value. The model is compared with the port outputs on every clock. Reads of the loaded half and of the other half in the next cycles show whether the increment was dropped and whether the untouched half stayed put.

// File: rtl/tally_pkg.sv
package tally_pkg;

  localparam int CNT_W = 64;
  localparam int HALF_W = 32;

  localparam logic [3:0] PAGE_RO = 4'hC;
  localparam logic [3:0] PAGE_SH = 4'hB;
  localparam logic [6:0] OFF_CYC = 7'h00;
  localparam logic [6:0] OFF_RET = 7'h02;

  typedef enum logic [0:0] {
    CTR_CYC = 1'b0,
    CTR_RET = 1'b1
  } ctr_id_e;

  typedef struct packed {
    logic    hit;
    logic    shadow;
    logic    upper;
    ctr_id_e id;
  } tally_dec_t;

endpackage

// File: rtl/tally_decode.sv
module tally_decode
  import tally_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [11:0] addr,
  output tally_dec_t  dec
);

  localparam bit SPLIT = (XLEN == 32);

  logic [3:0] page;
  logic [6:0] off;
  logic       upper_sel;
  logic       page_ok;
  logic       off_ok;

  always_comb begin
    page      = addr[11:8];
    off       = addr[6:0];
    upper_sel = addr[7];
    page_ok   = (page == PAGE_RO) || (page == PAGE_SH);
    off_ok    = (off == OFF_CYC) || (off == OFF_RET);
    dec.hit    = page_ok && off_ok && (!upper_sel || SPLIT);
    dec.shadow = (page == PAGE_SH);
    dec.upper  = upper_sel;
    dec.id     = (off == OFF_RET) ? CTR_RET : CTR_CYC;
  end

endmodule

// File: rtl/tally_counter.sv
module tally_counter
  import tally_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [XLEN-1:0]  wdata,
  output logic [CNT_W-1:0] value
);

  localparam logic [CNT_W-1:0] LO_MASK =
    (XLEN == CNT_W) ? {CNT_W{1'b1}} : {{(CNT_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  localparam logic [CNT_W-1:0] HI_MASK = ~LO_MASK;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (wr_lo) begin
      cnt_q[XLEN-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt_q[CNT_W-1:HALF_W] <= wdata[HALF_W-1:0];
    end else begin
      cnt_q <= cnt_q + CNT_W'(inc);
    end
  end

  assign value = cnt_q;

  // R2 and R3: an idle cycle adds exactly the increment request
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_lo && !wr_hi) |=> (cnt_q == $past(cnt_q) + CNT_W'($past(inc))));

  a_r6_lo_load: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_lo) |=> (((cnt_q & LO_MASK) == CNT_W'($past(wdata))) &&
                         (((cnt_q ^ $past(cnt_q)) & HI_MASK) == '0)));

  a_r7_hi_load: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_hi && !wr_lo) |=> ((cnt_q[CNT_W-1:HALF_W] == $past(wdata[HALF_W-1:0])) &&
                                    (cnt_q[HALF_W-1:0] == $past(cnt_q[HALF_W-1:0]))));

endmodule

// File: rtl/tally_bank.sv
module tally_bank
  import tally_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire_i,
  input  logic [11:0]     addr_i,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic            hit_o
);

  localparam int NUM_CTR = 2;

  tally_dec_t       dec;
  logic [NUM_CTR-1:0] wr_lo_v;
  logic [NUM_CTR-1:0] wr_hi_v;
  logic [NUM_CTR-1:0] inc_v;
  logic [CNT_W-1:0]   val [NUM_CTR];
  logic [CNT_W-1:0]   sel_val;
  logic [XLEN-1:0]    rd_next;
  logic               ld_ok;

  tally_decode #(.XLEN(XLEN)) u_dec (
    .addr (addr_i),
    .dec  (dec)
  );

  assign ld_ok = we_i && dec.hit && dec.shadow;

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    assign inc_v[g]   = (g == int'(CTR_CYC)) ? 1'b1 : retire_i;
    assign wr_lo_v[g] = ld_ok && !dec.upper && (int'(dec.id) == g);
    assign wr_hi_v[g] = ld_ok &&  dec.upper && (int'(dec.id) == g);

    tally_counter #(.XLEN(XLEN)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (inc_v[g]),
      .wr_lo (wr_lo_v[g]),
      .wr_hi (wr_hi_v[g]),
      .wdata (wdata_i),
      .value (val[g])
    );
  end

  always_comb begin
    sel_val = val[dec.id];
    if (!dec.hit)
      rd_next = '0;
    else if (dec.upper)
      rd_next = XLEN'(sel_val >> HALF_W);
    else
      rd_next = XLEN'(sel_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
      hit_o   <= 1'b0;
    end else begin
      rdata_o <= rd_next;
      hit_o   <= dec.hit;
    end
  end

  a_r8_ro_load_dropped: assert property (@(posedge clk) disable iff (rst)
    (we_i && !(addr_i[11:8] == PAGE_SH)) |-> ((wr_lo_v == '0) && (wr_hi_v == '0)));

  a_r9_hit_page: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (($past(addr_i[11:8]) == PAGE_RO) || ($past(addr_i[11:8]) == PAGE_SH)));

  a_r6_single_load: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_hi_v, wr_lo_v}));

  a_r1_clear: assert property (@(posedge clk)
    rst |=> ((rdata_o == '0) && !hit_o && (val[0] == '0) && (val[1] == '0)));

endmodule

// File: tb/tally_bank_tb.sv
module tally_bank_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        retire_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        hit_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [63:0] m_cyc;
  logic [63:0] m_ret;

  always #4 clk = ~clk;

  tally_bank #(.XLEN(32)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .retire_i (retire_i),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .hit_o    (hit_o)
  );

  // one clock: drive at a falling edge, predict, compare at the next falling edge
  task automatic step(input logic [11:0] a, input logic w, input logic [31:0] d,
                      input logic r, input string req);
    logic        e_hit;
    logic [31:0] e_rd;
    logic [63:0] v;
    logic        is_sh;
    addr_i = a; we_i = w; wdata_i = d; retire_i = r;
    e_hit = ((a[11:8] == 4'hC) || (a[11:8] == 4'hB)) &&
            ((a[6:0] == 7'h00) || (a[6:0] == 7'h02));
    is_sh = (a[11:8] == 4'hB);
    v = a[1] ? m_ret : m_cyc;
    e_rd = !e_hit ? 32'h0 : (a[7] ? v[63:32] : v[31:0]);
    // cycle counter model
    if (w && e_hit && is_sh && !a[1]) begin
      if (a[7]) m_cyc[63:32] = d; else m_cyc[31:0] = d;
    end else m_cyc = m_cyc + 64'd1;
    // retired counter model
    if (w && e_hit && is_sh && a[1]) begin
      if (a[7]) m_ret[63:32] = d; else m_ret[31:0] = d;
    end else m_ret = m_ret + {63'd0, r};
    @(negedge clk);
    checks++;
    if (rdata_o !== e_rd || hit_o !== e_hit) begin
      fails++;
      $display("FAIL %s addr=%h: rdata=%h hit=%b expected rdata=%h hit=%b",
               req, a, rdata_o, hit_o, e_rd, e_hit);
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    m_cyc = '0;
    m_ret = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (rdata_o !== 32'h0 || hit_o !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: rdata=%h hit=%b expected 0 0", rdata_o, hit_o);
    end
    rst = 1'b0;

    // R1/R2/R4 basic reads right after reset
    step(12'hC00, 0, 0, 0, "R1");
    step(12'hC00, 0, 0, 0, "R2");
    step(12'hC02, 0, 0, 1, "R4");
    // R3 retire patterns
    step(12'hC02, 0, 0, 0, "R3");
    step(12'hC02, 0, 0, 1, "R3");
    step(12'hC02, 0, 0, 1, "R3");
    step(12'hC02, 0, 0, 0, "R3");
    step(12'hC82, 0, 0, 0, "R4");
    // R5 shadow reads
    step(12'hB00, 0, 0, 0, "R5");
    step(12'hB02, 0, 0, 1, "R5");
    step(12'hB80, 0, 0, 0, "R5");
    step(12'hC80, 0, 0, 0, "R4");
    // R6 lower load then carry R10
    step(12'hB00, 1, 32'hFFFF_FFFC, 0, "R6");
    for (int i = 0; i < 5; i++) step(12'hC00, 0, 0, 0, "R10");
    step(12'hC80, 0, 0, 0, "R10");
    // R7 upper load
    step(12'hB80, 1, 32'h1234_5678, 1, "R7");
    step(12'hC80, 0, 0, 0, "R7");
    step(12'hB00, 0, 0, 0, "R7");
    // R6 load against a retire in the same cycle
    step(12'hB02, 1, 32'h0000_0100, 1, "R6");
    step(12'hC02, 0, 0, 1, "R6");
    step(12'hC02, 0, 0, 0, "R6");
    // R10 full wrap of the retired counter
    step(12'hB82, 1, 32'hFFFF_FFFF, 0, "R7");
    step(12'hB02, 1, 32'hFFFF_FFFE, 0, "R6");
    step(12'hC02, 0, 0, 1, "R10");
    step(12'hC02, 0, 0, 1, "R10");
    step(12'hC02, 0, 0, 0, "R10");
    step(12'hC82, 0, 0, 0, "R10");
    // R8 loads at read-only aliases are dropped
    step(12'hC00, 1, 32'hDEAD_BEEF, 0, "R8");
    step(12'hC82, 1, 32'hCAFE_F00D, 1, "R8");
    step(12'hC00, 0, 0, 0, "R8");
    step(12'hC82, 0, 0, 0, "R8");
    step(12'hC80, 0, 0, 0, "R8");
    // R9 unmatched addresses
    step(12'h300, 1, 32'h5555_5555, 0, "R9");
    step(12'hC01, 1, 32'h5555_5555, 1, "R9");
    step(12'hB81, 1, 32'h5555_5555, 0, "R9");
    step(12'hA00, 1, 32'h5555_5555, 0, "R9");
    step(12'hB40, 1, 32'h5555_5555, 0, "R9");
    step(12'hB00, 0, 0, 0, "R9");
    step(12'hB80, 0, 0, 0, "R9");
    step(12'hB02, 0, 0, 0, "R9");
    step(12'hB82, 0, 0, 0, "R9");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule